// File: doc/BRIEF.md
# Clock Status and Notification Registers

This block is the device-side register file that a host uses to take ownership of an audio streaming device, to choose its sample clock, to start and stop streaming, and to watch the health of every clock input. A transaction layer in front of it turns bus packets into single-cycle requests. Each request is a quadlet read, a quadlet write, or a 64-bit compare-and-swap. The block answers every request one cycle later.

The host claims the device by swapping its own 64-bit address into the owner register. The upper 16 bits of that address are the node ID and the lower 48 bits are an offset in that node. Configuration changes, clock lock changes and completed clock-select writes are events. An event replaces the contents of the event register. If an owner is present, the block also raises a request that the event word be written to the owner's address. Clock slips are recorded as sticky error flags that produce no notification. A bus reset releases ownership and stops streaming.

Register indices (quadlet offsets): 0 owner upper half, 1 owner lower half, 2 event word, 3 clock select, 4 stream enable, 5 clock status, 6 per-source status. Index 7 is unmapped.

Top module: `clksts_regs`

## Requirements
- R1: After `rst` the owner reads 0xFFFF_0000_0000_0000 (no owner), the event word and stream enable read 0, the clock select reads 0x0000_020C (internal source 0x0C, 48 kHz rate code 2), and the per-source status reads 0.
- R2: The owner register changes only through a compare-and-swap at index 0 (`req_op`=2). It loads `req_swap` only when its value equals `req_cmp`. The response always returns the value it held before the request. A quadlet write to index 0 or 1 has no effect.
- R3: A `bus_reset` pulse returns the owner to the no-owner value and clears stream enable. It takes priority over a request in the same cycle.
- R4: When any event occurs, the event word is loaded with only the new event bits and all earlier bits are dropped. Events in the same cycle merge into one word. One cycle later `ntf_valid` pulses for one cycle, with `ntf_mask` equal to that word and `ntf_addr` equal to the owner held when the event occurred.
- R5: No notification is raised while the owner holds the no-owner value. The event word is still updated.
- R6: A quadlet write to index 3 stores bits 15:0 (source in 7:0, rate code in 15:8) and raises event bit 0x20.
- R7: Pulses on `rx_cfg_chg` and `tx_cfg_chg` raise event bits 0x1 and 0x2. A change of `cur_locked` raises 0x10. A change in any bit of `src_locked` raises 0x40.
- R8: The per-source status word shows live `src_locked` in bits 0–10 and sticky slip flags in bits 16–26. A slip never raises an event. A quadlet read of index 6 returns the flags and then clears them, except that a slip arriving in the same cycle as that read stays set.
- R9: The clock status word at index 5 shows `cur_locked` in bit 0 and `nominal_rate` in bits 15:8.
- R10: A write to index 4 stores 1 if the written word is non-zero and 0 otherwise. The stored bit drives `stream_en` and reads back at index 4.
- R11: A quadlet read of index 7 returns 0. Quadlet read data appears in bits 31:0 of `rsp_rdata`, and bits 63:32 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset pulse |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 compare-and-swap |
| req_addr | input | 3 | Quadlet index |
| req_wdata | input | 32 | Write data |
| req_cmp | input | 64 | Compare operand |
| req_swap | input | 64 | Swap operand |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 64 | Read data or old owner value |
| rx_cfg_chg | input | 1 | Receive configuration changed pulse |
| tx_cfg_chg | input | 1 | Transmit configuration changed pulse |
| cur_locked | input | 1 | Current clock source locked level |
| nominal_rate | input | 8 | Measured nominal rate code |
| src_locked | input | 11 | Per-source lock levels |
| src_slip | input | 11 | Per-source slip pulses |
| clk_select | output | 16 | Stored clock select |
| stream_en | output | 1 | Stream enable |
| ntf_valid | output | 1 | Notification request pulse |
| ntf_mask | output | 32 | Event word to be sent |
| ntf_addr | output | 64 | Destination owner address |

## Verification
The assertions assume that `rst` is held for at least one edge before checking starts, and that lock and rate inputs are levels that change only between clock edges. They also assume `req_op` never takes the value 3. The bench drives every input on the falling edge and issues at most one request per cycle, always with one of the three defined operations. It sweeps all 32 combinations of the five event sources, including a clock-select write in the same cycle as input pulses, so that merged events occur within these limits.

// File: rtl/clksts_pkg.sv
package clksts_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CAS   = 2'd2
    } bus_op_e;

    typedef enum logic [2:0] {
        IDX_OWNER_HI = 3'd0,
        IDX_OWNER_LO = 3'd1,
        IDX_EVENT    = 3'd2,
        IDX_CLKSEL   = 3'd3,
        IDX_ENABLE   = 3'd4,
        IDX_STATUS   = 3'd5,
        IDX_EXTSTAT  = 3'd6,
        IDX_SPARE    = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [7:0] rate;
        logic [7:0] source;
    } clksel_t;

    localparam logic [63:0] NO_OWNER   = 64'hFFFF_0000_0000_0000;
    localparam logic [31:0] EV_RXCFG   = 32'h0000_0001;
    localparam logic [31:0] EV_TXCFG   = 32'h0000_0002;
    localparam logic [31:0] EV_LOCK    = 32'h0000_0010;
    localparam logic [31:0] EV_ACCEPT  = 32'h0000_0020;
    localparam logic [31:0] EV_EXT     = 32'h0000_0040;
    localparam logic [31:0] EV_ALL     = EV_RXCFG | EV_TXCFG | EV_LOCK | EV_ACCEPT | EV_EXT;
    localparam logic [7:0]  SRC_INTERNAL = 8'h0C;
    localparam logic [7:0]  RATE_48K     = 8'h02;
    localparam int          SLIP_LSB     = 16;

    function automatic logic [31:0] status_word(input logic locked, input logic [7:0] rate);
        return {16'h0, rate, 7'h0, locked};
    endfunction
endpackage

// File: rtl/clksts_owner.sv
module clksts_owner
    import clksts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_reset,
    input  logic        cas_en,
    input  logic [63:0] cmp,
    input  logic [63:0] swap,
    output logic [63:0] owner_q
);
    always_ff @(posedge clk) begin
        if (rst || bus_reset)
            owner_q <= NO_OWNER;
        else if (cas_en && (cmp == owner_q))
            owner_q <= swap;
    end

    // R2: any change must follow a matching swap or a bus reset
    a_r2_cas_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(owner_q) |-> $past(bus_reset || (cas_en && (cmp == owner_q))));

    // R3: bus reset releases ownership
    a_r3_owner_release: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (owner_q == NO_OWNER));
endmodule

// File: rtl/clksts_events.sv
module clksts_events
    import clksts_pkg::*;
#(
    parameter int N_SRC = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_chg,
    input  logic             tx_chg,
    input  logic             clk_acc,
    input  logic             cur_locked,
    input  logic [N_SRC-1:0] src_locked,
    input  logic [63:0]      owner_q,
    output logic [31:0]      ev_mask_q,
    output logic             ntf_valid,
    output logic [63:0]      ntf_addr
);
    logic             lock_prev;
    logic [N_SRC-1:0] src_prev;
    logic [31:0]      ev_now;

    always_comb begin
        ev_now = '0;
        if (rx_chg)                   ev_now |= EV_RXCFG;
        if (tx_chg)                   ev_now |= EV_TXCFG;
        if (cur_locked != lock_prev)  ev_now |= EV_LOCK;
        if (clk_acc)                  ev_now |= EV_ACCEPT;
        if (src_locked != src_prev)   ev_now |= EV_EXT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_prev <= 1'b0;
            src_prev  <= '0;
            ev_mask_q <= '0;
            ntf_valid <= 1'b0;
            ntf_addr  <= NO_OWNER;
        end else begin
            lock_prev <= cur_locked;
            src_prev  <= src_locked;
            ntf_valid <= (ev_now != '0) && (owner_q != NO_OWNER);
            if (ev_now != '0) begin
                ev_mask_q <= ev_now;
                ntf_addr  <= owner_q;
            end
        end
    end

    // R5: a request only goes out when an owner was present
    a_r5_owner_gate: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> ($past(owner_q) != NO_OWNER));

    // R4: the request targets the owner held at the event
    a_r4_target: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> (ntf_addr == $past(owner_q)));
endmodule

// File: rtl/clksts_slip.sv
module clksts_slip #(
    parameter int N_SRC = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [N_SRC-1:0] slip_in,
    output logic [N_SRC-1:0] slip_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                slip_q[i] <= 1'b0;
            else
                slip_q[i] <= slip_in[i] | (slip_q[i] & ~clr);
        end

        // R8: a slip is never lost, even against a clearing read
        a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
            slip_in[i] |=> slip_q[i]);
    end
endmodule

// File: rtl/clksts_regs.sv
module clksts_regs
    import clksts_pkg::*;
#(
    parameter int N_SRC = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [2:0]       req_addr,
    input  logic [31:0]      req_wdata,
    input  logic [63:0]      req_cmp,
    input  logic [63:0]      req_swap,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    input  logic             rx_cfg_chg,
    input  logic             tx_cfg_chg,
    input  logic             cur_locked,
    input  logic [7:0]       nominal_rate,
    input  logic [N_SRC-1:0] src_locked,
    input  logic [N_SRC-1:0] src_slip,
    output logic [15:0]      clk_select,
    output logic             stream_en,
    output logic             ntf_valid,
    output logic [31:0]      ntf_mask,
    output logic [63:0]      ntf_addr
);
    localparam int SLIP_MSB = SLIP_LSB + N_SRC - 1;

    bus_op_e          op;
    reg_idx_e         idx;
    logic             rd_en, wr_en, cas_en, clk_acc, slip_clr;
    logic [63:0]      owner_q;
    logic [N_SRC-1:0] slip_q;
    clksel_t          clksel_q;
    logic [31:0]      ext_word, rd_word;

    assign op       = bus_op_e'(req_op);
    assign idx      = reg_idx_e'(req_addr);
    assign rd_en    = req_valid && (op == OP_READ);
    assign wr_en    = req_valid && (op == OP_WRITE);
    assign cas_en   = req_valid && (op == OP_CAS) && (idx == IDX_OWNER_HI);
    assign clk_acc  = wr_en && (idx == IDX_CLKSEL);
    assign slip_clr = rd_en && (idx == IDX_EXTSTAT);

    clksts_owner u_owner (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .cas_en(cas_en),
        .cmp(req_cmp), .swap(req_swap), .owner_q(owner_q)
    );

    clksts_events #(.N_SRC(N_SRC)) u_events (
        .clk(clk), .rst(rst), .rx_chg(rx_cfg_chg), .tx_chg(tx_cfg_chg),
        .clk_acc(clk_acc), .cur_locked(cur_locked), .src_locked(src_locked),
        .owner_q(owner_q), .ev_mask_q(ntf_mask), .ntf_valid(ntf_valid),
        .ntf_addr(ntf_addr)
    );

    clksts_slip #(.N_SRC(N_SRC)) u_slip (
        .clk(clk), .rst(rst), .clr(slip_clr), .slip_in(src_slip), .slip_q(slip_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clksel_q <= '{rate: RATE_48K, source: SRC_INTERNAL};
        end else if (clk_acc) begin
            clksel_q <= clksel_t'(req_wdata[15:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset)
            stream_en <= 1'b0;
        else if (wr_en && (idx == IDX_ENABLE))
            stream_en <= (req_wdata != '0);
    end

    always_comb begin
        ext_word = '0;
        ext_word[N_SRC-1:0]         = src_locked;
        ext_word[SLIP_MSB:SLIP_LSB] = slip_q;
    end

    always_comb begin
        case (idx)
            IDX_OWNER_HI: rd_word = owner_q[63:32];
            IDX_OWNER_LO: rd_word = owner_q[31:0];
            IDX_EVENT:    rd_word = ntf_mask;
            IDX_CLKSEL:   rd_word = {16'h0, clksel_q};
            IDX_ENABLE:   rd_word = {31'h0, stream_en};
            IDX_STATUS:   rd_word = status_word(cur_locked, nominal_rate);
            IDX_EXTSTAT:  rd_word = ext_word;
            default:      rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (cas_en)      rsp_rdata <= owner_q;
            else if (rd_en)  rsp_rdata <= {32'h0, rd_word};
            else             rsp_rdata <= '0;
        end
    end

    assign clk_select = clksel_q;

    // R3: bus reset stops streaming
    a_r3_enable_clear: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !stream_en);

    // R6: a clock select write is acknowledged through the event word
    a_r6_accept: assert property (@(posedge clk) disable iff (rst)
        clk_acc |=> ((ntf_mask & EV_ACCEPT) != '0));

    // R11: one response per request, one cycle later
    a_r11_response: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R8: slips alone never enter the event word
    a_r8_no_slip_event: assert property (@(posedge clk) disable iff (rst)
        ((ntf_mask & ~EV_ALL) == '0));
endmodule

// File: tb/clksts_regs_bench.sv
module clksts_regs_bench;
    localparam int N = 11;
    localparam logic [63:0] NOOWN = 64'hFFFF_0000_0000_0000;
    localparam logic [63:0] OWN_A = 64'h0003_0000_0000_1000;

    logic clk = 0, rst = 1, bus_reset = 0, req_valid = 0;
    logic [1:0] req_op = 0;
    logic [2:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic [63:0] req_cmp = 0, req_swap = 0;
    logic rsp_valid;
    logic [63:0] rsp_rdata;
    logic rx_cfg_chg = 0, tx_cfg_chg = 0, cur_locked = 0;
    logic [7:0] nominal_rate = 0;
    logic [N-1:0] src_locked = 0, src_slip = 0;
    logic [15:0] clk_select;
    logic stream_en, ntf_valid;
    logic [31:0] ntf_mask;
    logic [63:0] ntf_addr;

    int nchk = 0, nerr = 0;
    bit done = 0;
    logic [63:0] rd;

    clksts_regs #(.N_SRC(N)) u_clksts_regs (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus(input logic [1:0] op, input logic [2:0] a, input logic [31:0] wd,
                       input logic [63:0] c, input logic [63:0] s, output logic [63:0] r);
        req_valid = 1; req_op = op; req_addr = a; req_wdata = wd; req_cmp = c; req_swap = s;
        tick();
        req_valid = 0;
        r = rsp_rdata;
        chk("R11 rsp_valid", {63'h0, rsp_valid}, 64'h1);
    endtask

    task automatic rdq(input logic [2:0] a, output logic [63:0] r);
        bus(2'd0, a, 32'h0, 64'h0, 64'h0, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog R1..R11 not finished: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_mask;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ntf_mask", {32'h0, ntf_mask}, 0);
        chk("R1 clk_select", {48'h0, clk_select}, 64'h020C);
        chk("R1 stream_en", {63'h0, stream_en}, 0);
        rdq(3'd0, rd); chk("R1 owner hi", rd, 64'hFFFF0000);
        rdq(3'd1, rd); chk("R1 owner lo", rd, 0);
        rdq(3'd6, rd); chk("R1 ext status", rd, 0);
        rdq(3'd3, rd); chk("R1 clksel read", rd, 64'h020C);

        // R2 compare-and-swap
        bus(2'd2, 3'd0, 0, 64'h0, OWN_A, rd); chk("R2 cas miss old", rd, NOOWN);
        rdq(3'd0, rd); chk("R2 cas miss kept", rd, 64'hFFFF0000);
        bus(2'd2, 3'd0, 0, NOOWN, OWN_A, rd); chk("R2 cas hit old", rd, NOOWN);
        rdq(3'd0, rd); chk("R2 owner hi", rd, OWN_A[63:32]);
        rdq(3'd1, rd); chk("R2 owner lo", rd, OWN_A[31:0]);
        bus(2'd1, 3'd0, 32'h1234, 0, 0, rd);
        bus(2'd1, 3'd1, 32'h5678, 0, 0, rd);
        rdq(3'd0, rd); chk("R2 write ignored hi", rd, OWN_A[63:32]);
        rdq(3'd1, rd); chk("R2 write ignored lo", rd, OWN_A[31:0]);
        chk("R2 no spurious ntf", {63'h0, ntf_valid}, 0);

        // R4/R6/R7 sweep of all event-source combinations
        exp_mask = 0;
        for (int k = 0; k < 32; k++) begin
            logic [15:0] sel;
            sel = {8'(k % 7), 8'(k % 13)};
            rx_cfg_chg = k[0];
            tx_cfg_chg = k[1];
            if (k[2]) cur_locked = ~cur_locked;
            if (k[4]) src_locked[k % N] = ~src_locked[k % N];
            if (k[3]) begin
                req_valid = 1; req_op = 2'd1; req_addr = 3'd3; req_wdata = {16'hABCD, sel};
            end
            tick();
            req_valid = 0; rx_cfg_chg = 0; tx_cfg_chg = 0;
            if (k != 0)
                exp_mask = (k[0] ? 32'h1 : 0) | (k[1] ? 32'h2 : 0) | (k[2] ? 32'h10 : 0)
                         | (k[3] ? 32'h20 : 0) | (k[4] ? 32'h40 : 0);
            chk($sformatf("R4 ntf_valid k=%0d", k), {63'h0, ntf_valid}, {63'h0, k != 0});
            chk($sformatf("R7 ntf_mask k=%0d", k), {32'h0, ntf_mask}, {32'h0, exp_mask});
            if (k != 0) chk($sformatf("R4 ntf_addr k=%0d", k), ntf_addr, OWN_A);
            if (k[3]) chk($sformatf("R6 clk_select k=%0d", k), {48'h0, clk_select}, {48'h0, sel});
            tick();
            chk($sformatf("R4 single pulse k=%0d", k), {63'h0, ntf_valid}, 0);
        end
        rdq(3'd2, rd); chk("R4 event read", rd, {32'h0, exp_mask});

        // R10 stream enable
        bus(2'd1, 3'd4, 32'h0100_0000, 0, 0, rd);
        chk("R10 enable set", {63'h0, stream_en}, 1);
        rdq(3'd4, rd); chk("R10 enable read", rd, 1);
        bus(2'd1, 3'd4, 32'h0, 0, 0, rd);
        chk("R10 enable clear", {63'h0, stream_en}, 0);
        bus(2'd1, 3'd4, 32'h1, 0, 0, rd);

        // R3 bus reset over simultaneous swap
        bus_reset = 1;
        req_valid = 1; req_op = 2'd2; req_addr = 3'd0; req_cmp = OWN_A; req_swap = 64'h7;
        tick();
        bus_reset = 0; req_valid = 0;
        chk("R3 enable cleared", {63'h0, stream_en}, 0);
        rdq(3'd0, rd); chk("R3 owner released hi", rd, 64'hFFFF0000);
        rdq(3'd1, rd); chk("R3 owner released lo", rd, 0);

        // R5 no owner: mask updates, no request
        rx_cfg_chg = 1; tick(); rx_cfg_chg = 0;
        chk("R5 no ntf", {63'h0, ntf_valid}, 0);
        chk("R5 mask updated", {32'h0, ntf_mask}, 1);
        tx_cfg_chg = 1; tick(); tx_cfg_chg = 0;
        chk("R5 no ntf tx", {63'h0, ntf_valid}, 0);

        // R9 clock status over all rate codes
        for (int r = 0; r < 11; r++) begin
            nominal_rate = 8'(r);
            cur_locked = r[0];
            tick();
            rdq(3'd5, rd);
            chk($sformatf("R9 status r=%0d", r), rd, {48'h0, 8'(r), 7'h0, r[0]});
        end

        // R8 slip flags per source, owner present, no notification
        bus(2'd2, 3'd0, 0, NOOWN, OWN_A, rd);
        src_locked = 11'h2A5;
        tick(); tick();
        for (int i = 0; i < N; i++) begin
            logic [31:0] ew;
            src_slip[i] = 1; tick(); src_slip[i] = 0;
            chk($sformatf("R8 no ntf slip %0d", i), {63'h0, ntf_valid}, 0);
            ew = 32'h2A5; ew[16 + i] = 1'b1;
            rdq(3'd6, rd); chk($sformatf("R8 slip set %0d", i), rd, {32'h0, ew});
            rdq(3'd6, rd); chk($sformatf("R8 slip cleared %0d", i), rd, 64'h2A5);
        end
        // R8 slip coinciding with clearing read stays set
        src_slip[0] = 1; tick(); src_slip[0] = 0;
        src_slip[3] = 1;
        rdq(3'd6, rd);
        src_slip[3] = 0;
        chk("R8 read before clear", rd, 64'h0001_02A5);
        rdq(3'd6, rd); chk("R8 coincident slip kept", rd, 64'h0008_02A5);
        rdq(3'd6, rd); chk("R8 cleared after", rd, 64'h2A5);

        // R11 unmapped index
        rdq(3'd7, rd); chk("R11 unmapped", rd, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule